// File: doc/BRIEF.md
# Control State Machine with Subroutine State Stack

This block is a synchronous control unit whose state is held in a small stack of frames instead of a single state register. Each frame holds a state code and a one-bit completion mark. The next-state logic reads only the top frame. A call pushes the caller, with its mark set, into the saved area and starts a shared state sequence in the new top frame. A return pops the stack, so the machine is back in the calling state itself. The set mark then steers the caller onto its onward edge instead of making the call again.

The built-in program has a main loop with two callers of one four-state shared routine. The routine exists once in hardware. The first pass emits the codes 1,2,3,4,5,6 and the second pass emits 7,2,3,4,5,8, leaving out the idle code 0 that the callers emit. The machine makes one transition per clock while the advance enable is high.

Two parameters change the build. One sets the stack depth. The other swaps the end of the main loop for a return that has no matching call, which exercises the empty-stack error.

Top module: `substack_fsm`

## Requirements
- R1: While reset is high and on the first cycle after it falls, cur_state is 0 (P1), out_code is 1, and both error outputs are 0.
- R2: While en is low, cur_state, out_code and both error outputs keep their values.
- R3: A caller state entered with its mark clear (C1 = 1 or C2 = 8) moves next to the routine entry S2 = 2 and pushes one frame.
- R4: From the routine's last state S5 = 5, the next state is the caller that made the call (1 or 8), not that caller's successor.
- R5: A caller re-entered after a return takes its onward edge: C1 goes to P6 = 6, and C2 goes to P8 = 9.
- R6: From reset with en held high, cur_state repeats the 16-step order 0,1,2,3,4,5,1,6,7,8,2,3,4,5,8,9. The nonzero out_code values form the stream 1,2,3,4,5,6,7,2,3,4,5,8.
- R7: The caller's mark is cleared when it takes its onward edge, so every later loop calls the routine again from both callers.
- R8: With a stack depth of 1, the call from C1 sets err_overflow. The flag stays set until reset, and the machine stays in C1 with the stack unchanged.
- R9: With the unmatched-return variant, the return in P8 = 9 with a single frame sets err_underflow. The flag stays set until reset, and the machine stays in P8.
- R10: out_code always matches cur_state in the same cycle: P1→1, C1→0, S2→2, S3→3, S4→4, S5→5, P6→6, P7→7, C2→0, P8→8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable, one transition per clock while high |
| out_code | output | 4 | Registered Moore output code of the current state |
| cur_state | output | 4 | State code of the top frame |
| err_overflow | output | 1 | Sticky flag: a call was made with the stack full |
| err_underflow | output | 1 | Sticky flag: a return was made with a single frame |

## Verification
The hardest situation to reach is the second entry into a caller. Here the same state code must take a different edge, and only a frame popped from the saved area can show it. The ports show no stack contents, so the stimulus runs complete loops with en held high and compares every cycle against a behavioural queue model. It then checks directly the cycles just after each return. The two error conditions cannot occur in a correct program at the default depth. Two extra instances reach them: one built with a single-frame stack and one built with the unmatched-return variant.

// File: rtl/substack_pkg.sv
`timescale 1ns/1ps
package substack_pkg;
  localparam int ST_W   = 4;
  localparam int CODE_W = 4;

  typedef enum logic [ST_W-1:0] {
    ST_P1 = 4'd0, ST_C1 = 4'd1, ST_S2 = 4'd2, ST_S3 = 4'd3, ST_S4 = 4'd4,
    ST_S5 = 4'd5, ST_P6 = 4'd6, ST_P7 = 4'd7, ST_C2 = 4'd8, ST_P8 = 4'd9
  } state_e;

  typedef enum logic [1:0] {ACT_STEP = 2'd0, ACT_CALL = 2'd1, ACT_RET = 2'd2} act_e;

  typedef struct packed {
    state_e st;
    logic   done;
  } frame_t;

  localparam frame_t RESET_FRAME = '{st: ST_P1, done: 1'b0};

  function automatic logic [CODE_W-1:0] code_of(input state_e s);
    logic [CODE_W-1:0] c;
    case (s)
      ST_P1:   c = CODE_W'(1);
      ST_S2:   c = CODE_W'(2);
      ST_S3:   c = CODE_W'(3);
      ST_S4:   c = CODE_W'(4);
      ST_S5:   c = CODE_W'(5);
      ST_P6:   c = CODE_W'(6);
      ST_P7:   c = CODE_W'(7);
      ST_P8:   c = CODE_W'(8);
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/substack_prog.sv
`timescale 1ns/1ps
module substack_prog
  import substack_pkg::*;
#(
  parameter bit BAD_RETURN = 1'b0
) (
  input  frame_t top,
  output act_e   act,
  output frame_t nxt,
  output frame_t saved
);
  logic tail_ret;

  generate
    if (BAD_RETURN) begin : g_tail_ret
      assign tail_ret = 1'b1;
    end else begin : g_tail_loop
      assign tail_ret = 1'b0;
    end
  endgenerate

  always_comb begin
    act   = ACT_STEP;
    nxt   = '{st: top.st, done: 1'b0};
    saved = '{st: top.st, done: 1'b1};
    case (top.st)
      ST_P1: nxt.st = ST_C1;
      ST_C1: begin
        if (!top.done) begin
          act    = ACT_CALL;
          nxt.st = ST_S2;
        end else begin
          nxt.st = ST_P6;
        end
      end
      ST_S2: nxt.st = ST_S3;
      ST_S3: nxt.st = ST_S4;
      ST_S4: nxt.st = ST_S5;
      ST_S5: act    = ACT_RET;
      ST_P6: nxt.st = ST_P7;
      ST_P7: nxt.st = ST_C2;
      ST_C2: begin
        if (!top.done) begin
          act    = ACT_CALL;
          nxt.st = ST_S2;
        end else begin
          nxt.st = ST_P8;
        end
      end
      ST_P8: begin
        if (tail_ret) act = ACT_RET;
        else          nxt.st = ST_P1;
      end
      default: nxt.st = ST_P1;
    endcase
  end
endmodule

// File: rtl/substack_stack.sv
`timescale 1ns/1ps
module substack_stack
  import substack_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  act_e   act,
  input  frame_t nxt,
  input  frame_t saved,
  output frame_t top_q,
  output frame_t top_d,
  output logic   err_ovf_q,
  output logic   err_unf_q
);
  localparam int SLOTS = (DEPTH > 1) ? DEPTH - 1 : 1;
  localparam int IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int LW    = $clog2(DEPTH + 1);

  logic [LW-1:0] lvl_q;
  frame_t        mem [SLOTS];
  logic          full, single, do_push, do_pop, ovf_hit, unf_hit;
  logic [IW-1:0] wr_idx, rd_idx;

  assign full    = (int'(lvl_q) == DEPTH);
  assign single  = (int'(lvl_q) == 1);
  assign do_push = en && (act == ACT_CALL) && !full;
  assign do_pop  = en && (act == ACT_RET) && !single;
  assign ovf_hit = en && (act == ACT_CALL) && full;
  assign unf_hit = en && (act == ACT_RET) && single;
  assign wr_idx  = IW'(int'(lvl_q) - 1);
  assign rd_idx  = IW'(int'(lvl_q) - 2);

  always_comb begin
    if (do_push)                        top_d = nxt;
    else if (do_pop)                    top_d = mem[rd_idx];
    else if (en && (act == ACT_STEP))   top_d = nxt;
    else                                top_d = top_q;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= saved;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q     <= RESET_FRAME;
      lvl_q     <= LW'(1);
      err_ovf_q <= 1'b0;
      err_unf_q <= 1'b0;
    end else begin
      top_q <= top_d;
      if (do_push)     lvl_q <= lvl_q + LW'(1);
      else if (do_pop) lvl_q <= lvl_q - LW'(1);
      if (ovf_hit) err_ovf_q <= 1'b1;
      if (unf_hit) err_unf_q <= 1'b1;
    end
  end

  // R3: a call grows the stack by exactly one frame
  p_push_grow_r3: assert property (@(posedge clk) disable iff (rst)
    do_push |=> (lvl_q == $past(lvl_q) + LW'(1)));
  // R4: a return shrinks the stack and restores a caller whose mark is set
  p_pop_restore_r4: assert property (@(posedge clk) disable iff (rst)
    do_pop |=> ((lvl_q == $past(lvl_q) - LW'(1)) && top_q.done));
  // R8: a call into a full stack flags and changes nothing
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (en && (act == ACT_CALL) && full) |=> (err_ovf_q && $stable(lvl_q) && $stable(top_q)));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_ovf_q |=> err_ovf_q);
  // R9: a return from a single frame flags and holds the state
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    (en && (act == ACT_RET) && single) |=> (err_unf_q && $stable(top_q)));
  p_unf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_unf_q |=> err_unf_q);
endmodule

// File: rtl/substack_outdec.sv
`timescale 1ns/1ps
module substack_outdec
  import substack_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  state_e            st_d,
  output logic [CODE_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst) code_q <= code_of(ST_P1);
    else     code_q <= code_of(st_d);
  end
endmodule

// File: rtl/substack_fsm.sv
`timescale 1ns/1ps
module substack_fsm
  import substack_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter bit BAD_RETURN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [CODE_W-1:0] out_code,
  output logic [ST_W-1:0]   cur_state,
  output logic              err_overflow,
  output logic              err_underflow
);
  frame_t top_q, top_d, nxt, saved;
  act_e   act;

  substack_prog #(.BAD_RETURN(BAD_RETURN)) u_prog (
    .top(top_q), .act(act), .nxt(nxt), .saved(saved)
  );

  substack_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .en(en), .act(act), .nxt(nxt), .saved(saved),
    .top_q(top_q), .top_d(top_d), .err_ovf_q(err_overflow), .err_unf_q(err_underflow)
  );

  substack_outdec u_dec (
    .clk(clk), .rst(rst), .st_d(top_d.st), .code_q(out_code)
  );

  assign cur_state = top_q.st;

  // R1: reset puts the machine in P1
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (cur_state == ST_P1));
  // R2: nothing moves while enable is low
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cur_state) && $stable(out_code)));
  // R4: leaving the routine lands on a caller
  p_ret_caller_r4: assert property (@(posedge clk) disable iff (rst)
    (en && (cur_state == ST_S5)) |=> ((cur_state == ST_C1) || (cur_state == ST_C2)));
  // R10: the caller states emit the idle code
  p_caller_idle_r10: assert property (@(posedge clk) disable iff (rst)
    ((cur_state == ST_C1) || (cur_state == ST_C2)) |-> (out_code == '0));
endmodule

// File: tb/tb_substack_fsm.sv
`timescale 1ns/1ps
module tb_substack_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [3:0] code_a, st_a, code_o, st_o, code_u, st_u;
  logic eo_a, eu_a, eo_o, eu_o, eo_u, eu_u;
  int n_chk = 0;
  int n_err = 0;
  int ms[$];
  int trace[$];
  int codes[$];
  bit done_run = 1'b0;

  always #4 clk = ~clk;

  substack_fsm dut (.clk(clk), .rst(rst), .en(en), .out_code(code_a), .cur_state(st_a),
    .err_overflow(eo_a), .err_underflow(eu_a));
  substack_fsm #(.DEPTH(1)) dut_ovf (.clk(clk), .rst(rst), .en(en), .out_code(code_o),
    .cur_state(st_o), .err_overflow(eo_o), .err_underflow(eu_o));
  substack_fsm #(.BAD_RETURN(1'b1)) dut_unf (.clk(clk), .rst(rst), .en(en), .out_code(code_u),
    .cur_state(st_u), .err_overflow(eo_u), .err_underflow(eu_u));

  function automatic int exp_code(input int s);
    case (s)
      0: return 1; 2: return 2; 3: return 3; 4: return 4; 5: return 5;
      6: return 6; 7: return 7; 9: return 8; default: return 0;
    endcase
  endfunction

  // behavioural model: queue of frames, each coded as state*2 + mark
  initial ms = {0};
  always @(posedge clk) begin
    int t, s, d, k;
    if (rst) ms = {0};
    else if (en) begin
      k = ms.size() - 1;
      t = ms[k]; s = t / 2; d = t % 2;
      case (s)
        1: if (d == 0) begin ms[k] = 3; ms.push_back(4); end else ms[k] = 12;
        8: if (d == 0) begin ms[k] = 17; ms.push_back(4); end else ms[k] = 18;
        5: void'(ms.pop_back());
        9: ms[k] = 0;
        7: ms[k] = 16;
        default: ms[k] = (s + 1) * 2;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_model(input string req);
    int ms_st;
    ms_st = ms[ms.size()-1] / 2;
    chk(int'(st_a) == ms_st, req, int'(st_a), ms_st);
    chk(int'(code_a) == exp_code(int'(st_a)), "R10 code vs state", int'(code_a), exp_code(int'(st_a)));
  endtask

  initial begin
    int exp_tr[16] = '{0,1,2,3,4,5,1,6,7,8,2,3,4,5,8,9};
    int exp_cd[12] = '{1,2,3,4,5,6,7,2,3,4,5,8};
    int hold_st, hold_cd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(st_a == 4'd0, "R1 state in reset", int'(st_a), 0);
    chk(code_a == 4'd1, "R1 code in reset", int'(code_a), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(st_a == 4'd0, "R1 state after reset", int'(st_a), 0);
    chk(code_a == 4'd1, "R1 code after reset", int'(code_a), 1);
    chk(eo_a == 1'b0 && eu_a == 1'b0, "R1 errors clear", int'(eo_a) + int'(eu_a), 0);
    chk(st_o == 4'd0 && st_u == 4'd0, "R1 variants in P1", int'(st_o) + int'(st_u), 0);
    trace.push_back(int'(st_a));
    codes.push_back(int'(code_a));
    en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cmp_model("R6 per-cycle state");
      trace.push_back(int'(st_a));
      if (code_a != 4'd0) codes.push_back(int'(code_a));
    end
    for (int i = 0; i < 16; i++)
      chk(trace[i] == exp_tr[i], "R6 visit order", trace[i], exp_tr[i]);
    for (int i = 0; i < 12; i++)
      chk(codes[i] == exp_cd[i], "R6 code stream", codes[i], exp_cd[i]);
    chk(trace[2] == 2, "R3 call from C1", trace[2], 2);
    chk(trace[10] == 2, "R3 call from C2", trace[10], 2);
    chk(trace[6] == 1, "R4 return to C1", trace[6], 1);
    chk(trace[14] == 8, "R4 return to C2", trace[14], 8);
    chk(trace[7] == 6, "R5 onward from C1", trace[7], 6);
    chk(trace[15] == 9, "R5 onward from C2", trace[15], 9);
    chk(trace[18] == 2, "R7 second pass call C1", trace[18], 2);
    chk(trace[23] == 6, "R7 second pass onward C1", trace[23], 6);
    chk(trace[26] == 2, "R7 second pass call C2", trace[26], 2);
    chk(trace[34] == 2, "R7 third pass call C1", trace[34], 2);
    chk(eo_a == 1'b0 && eu_a == 1'b0, "R8 no spurious error", int'(eo_a) + int'(eu_a), 0);
    chk(st_o == 4'd1, "R8 stuck in C1", int'(st_o), 1);
    chk(eo_o == 1'b1, "R8 overflow flag", int'(eo_o), 1);
    chk(eu_o == 1'b0, "R8 no underflow", int'(eu_o), 0);
    chk(st_u == 4'd9, "R9 stuck in P8", int'(st_u), 9);
    chk(code_u == 4'd8, "R9 code of P8", int'(code_u), 8);
    chk(eu_u == 1'b1, "R9 underflow flag", int'(eu_u), 1);
    chk(eo_u == 1'b0, "R9 no overflow", int'(eo_u), 0);
    hold_st = int'(st_a);
    hold_cd = int'(code_a);
    en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(int'(st_a) == hold_st, "R2 state held", int'(st_a), hold_st);
      chk(int'(code_a) == hold_cd, "R2 code held", int'(code_a), hold_cd);
      chk(eo_o == 1'b1 && eu_u == 1'b1, "R2 flags held", int'(eo_o) + int'(eu_u), 2);
    end
    en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cmp_model("R7 model after pause");
    end
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(st_a == 4'd0, "R1 state after mid reset", int'(st_a), 0);
    chk(code_a == 4'd1, "R1 code after mid reset", int'(code_a), 1);
    chk(eo_o == 1'b0 && eu_u == 1'b0, "R1 flags cleared", int'(eo_o) + int'(eu_u), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      cmp_model("R6 restart");
    end
    done_run = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1600000;
    if (!done_run) begin
      n_chk++;
      n_err++;
      $display("FAIL R6 watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule